// File: doc/BRIEF.md
# Port Event Latch and Interrupt Bank

This block is the event side of the register file in a four-port power-sourcing controller. Hardware engines elsewhere on the chip raise single-cycle pulses when something happens on a port: power-good or power-enable changes, classification or detection done, disconnect, over-current cut, current limit, start fault. Supply conditions raise pulses too. The bank makes each pulse sticky in a byte-wide event register. It folds those registers into an eight-flag interrupt summary, and it drives an active-low interrupt line gated by a mask byte and a global enable.

A host reaches the bank through a flat command-code port: an 8-bit code, write data, a write strobe, a read strobe and read data. The serial framing that produces these lies outside this block. `rd_data` follows `cmd_addr` combinationally. `rd_en` matters only for reads with a side effect, and that side effect takes place at the clock edge that ends the read cycle. Every event register appears at two codes. The even code is a plain view. The odd code returns the same byte and clears it. A write-only command code produces self-clearing pulses: clear every event, release the interrupt line, request an IC reset, and request a reset of single ports.

Top module: `pse_evt_bank`

## Requirements
- R1: After reset, code 00h reads 80h, code 01h reads 80h, code 17h reads 80h, code 0Ah reads 70h, and codes 02h, 04h, 06h and 08h read 00h. Because the supply flag is unmasked and enabled, `irq_n` is 0.
- R2: A pulse latches into its event bit and stays there until it is cleared. The layout of each event register is as follows:
  - 02h: power-good change for ports 4..1 in bits 7:4, and power-enable change in bits 3:0.
  - 04h: classification done in bits 7:4, and detection done in bits 3:0.
  - 06h: disconnect in bits 7:4, and over-current cut in bits 3:0.
  - 08h: current-limit fault in bits 7:4, and start fault in bits 3:0.
  - In every field, port n is bit n-1 of that field.
- R3: A read at an even event code has no side effect. A read with `rd_en` at the odd code one above it returns the same byte and clears the register at that clock edge.
- R4: Code 0Ah holds the supply events in its upper bits: thermal shutdown in bit 7, digital-supply undervoltage in bit 6, digital-supply warning in bit 5 and power-supply undervoltage in bit 4. Bits 3:0 always read 0. Code 0Bh is the clearing alias of 0Ah.
- R5: Code 00h is a read-only summary. Each flag is the OR of its source bits. Bit 7 covers the supply register, bit 6 all of 08h, bit 5 is 06h[3:0], bit 4 is 04h[7:4], bit 3 is 04h[3:0], bit 2 is 06h[7:4], bit 1 is 02h[7:4] and bit 0 is 02h[3:0].
- R6: Code 01h is a read/write mask with one bit per summary flag. Bit 7 of code 17h is a read/write global enable. The other bits of 17h read 0.
- R7: `irq_n` is 0 exactly when three conditions hold: the global enable is 1, some summary flag ANDed with its mask bit is 1, and the line has not been released.
- R8: Writing code 1Ah with bit 6 set releases the line, so `irq_n` goes to 1 while the flags stay set. The line re-arms only when a pulse lands in a summary category whose mask bit is 1.
- R9: Writing code 1Ah with bit 7 set clears all five event registers at that edge.
- R10: A pulse that arrives in the same cycle as a clearing read or a clear-all is kept, so its bit reads 1 afterwards.
- R11: A write of code 1Ah produces pulses in the next cycle, each lasting exactly one cycle. Bit 4 drives `ic_rst_req` and bits 3:0 drive `port_rst_req`. Code 1Ah reads 00h.
- R12: Writes to any code other than 01h, 17h and 1Ah are ignored. Codes that are not mapped read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_addr | input | 8 | Command code |
| wr_data | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; enables clear-on-read |
| rd_data | output | 8 | Byte at `cmd_addr` |
| ev_pg_chg | input | 4 | Power-good change pulses, ports 4..1 |
| ev_pe_chg | input | 4 | Power-enable change pulses |
| ev_cls_done | input | 4 | Classification done pulses |
| ev_det_done | input | 4 | Detection done pulses |
| ev_disc | input | 4 | Disconnect pulses |
| ev_ocut | input | 4 | Over-current cut pulses |
| ev_ilim | input | 4 | Current-limit fault pulses |
| ev_start | input | 4 | Start fault pulses |
| ev_supply | input | 4 | Supply pulses: thermal, digital UV, digital warning, power UV (bit 3..0) |
| irq_n | output | 1 | Interrupt line, active low |
| ic_rst_req | output | 1 | One-cycle IC reset request |
| port_rst_req | output | 4 | One-cycle per-port reset requests |

## Verification
Some properties hold in every cycle and are checked that way. A pulse is never lost. A clearing read or a clear-all with no coincident pulse leaves the register empty. The reserved supply bits stay 0. The interrupt line is low only when it is enabled and some flag is unmasked, and it stays high while the enable is off. A reset request appears only after a write to the command code. Other behaviour needs the bench's scenarios. These are the exact field positions and summary mapping, the even and odd read pairing, the release of the line followed by re-arming on a masked-in event but not on a masked-out one, and the outcome when a pulse meets a clear in the same cycle.

// File: rtl/pse_evt_pkg.sv
`timescale 1ns/1ps
package pse_evt_pkg;
    localparam int PORTS    = 4;
    localparam int BYTE_W   = 8;
    localparam int EV_REGS  = 5;             // four port event bytes + supply byte
    localparam int SUP_IDX  = EV_REGS - 1;

    typedef logic [BYTE_W-1:0]               byte_t;
    typedef logic [EV_REGS-1:0][BYTE_W-1:0]  ev_bank_t;

    localparam byte_t A_SUM     = 8'h00;
    localparam byte_t A_MASK    = 8'h01;
    localparam byte_t A_EV_BASE = 8'h02;
    localparam byte_t A_GEN     = 8'h17;
    localparam byte_t A_CMD     = 8'h1A;

    localparam byte_t SUP_RST   = 8'h70;
    localparam byte_t SUP_VALID = 8'hF0;
    localparam byte_t MASK_RST  = 8'h80;
    localparam int    GEN_EN_BIT = BYTE_W - 1;

    // command byte bit positions
    localparam int C_CLR_ALL = 7;
    localparam int C_RELEASE = 6;
    localparam int C_IC_RST  = 4;

    typedef struct packed {
        logic             clr_all;
        logic             release_irq;
        logic             ic_rst;
        logic [PORTS-1:0] port_rst;
    } cmd_t;

    // Plain-view code of event register i; the clearing alias is one higher.
    function automatic byte_t ev_addr(input int i);
        return A_EV_BASE + byte_t'(2 * i);
    endfunction

    // Fold the event bank into the eight summary flags.
    function automatic byte_t summarize(input ev_bank_t e);
        byte_t s;
        s[7] = |e[SUP_IDX];
        s[6] = |e[3];
        s[5] = |e[2][PORTS-1:0];
        s[4] = |e[1][2*PORTS-1:PORTS];
        s[3] = |e[1][PORTS-1:0];
        s[2] = |e[2][2*PORTS-1:PORTS];
        s[1] = |e[0][2*PORTS-1:PORTS];
        s[0] = |e[0][PORTS-1:0];
        return s;
    endfunction

    function automatic cmd_t decode_cmd(input byte_t d);
        cmd_t c;
        c.clr_all     = d[C_CLR_ALL];
        c.release_irq = d[C_RELEASE];
        c.ic_rst      = d[C_IC_RST];
        c.port_rst    = d[PORTS-1:0];
        return c;
    endfunction
endpackage

// File: rtl/pse_evt_reg.sv
`timescale 1ns/1ps
module pse_evt_reg
    import pse_evt_pkg::*;
#(
    parameter byte_t RST_VAL = 8'h00,
    parameter byte_t VALID   = 8'hFF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  byte_t set,
    output byte_t q
);
    // a coincident set survives the clear
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= ((clr ? '0 : q) | set) & VALID;
    end
endmodule

// File: rtl/pse_evt_cmd.sv
`timescale 1ns/1ps
module pse_evt_cmd
    import pse_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  byte_t            wr_data,
    output cmd_t             now,
    output logic             ic_rst_req,
    output logic [PORTS-1:0] port_rst_req
);
    cmd_t dec;

    always_comb begin
        dec = decode_cmd(wr_data);
        now = hit ? dec : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ic_rst_req   <= 1'b0;
            port_rst_req <= '0;
        end else begin
            ic_rst_req   <= now.ic_rst;
            port_rst_req <= now.port_rst;
        end
    end
endmodule

// File: rtl/pse_evt_irq.sv
`timescale 1ns/1ps
module pse_evt_irq
    import pse_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_mask,
    input  logic  wr_gen,
    input  byte_t wr_data,
    input  byte_t sum,
    input  byte_t new_sum,
    input  logic  release_req,
    output byte_t mask_q,
    output logic  gen_en,
    output logic  irq_n
);
    logic released;
    logic rearm;

    assign rearm = |(new_sum & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= MASK_RST;
            gen_en   <= 1'b1;
            released <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wr_data;
            if (wr_gen)  gen_en <= wr_data[GEN_EN_BIT];
            if (rearm)            released <= 1'b0;
            else if (release_req) released <= 1'b1;
        end
    end

    assign irq_n = !(gen_en && (|(sum & mask_q)) && !released);
endmodule

// File: rtl/pse_evt_bank.sv
`timescale 1ns/1ps
module pse_evt_bank
    import pse_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cmd_addr,
    input  logic [7:0]       wr_data,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    input  logic [3:0]       ev_pg_chg,
    input  logic [3:0]       ev_pe_chg,
    input  logic [3:0]       ev_cls_done,
    input  logic [3:0]       ev_det_done,
    input  logic [3:0]       ev_disc,
    input  logic [3:0]       ev_ocut,
    input  logic [3:0]       ev_ilim,
    input  logic [3:0]       ev_start,
    input  logic [3:0]       ev_supply,
    output logic             irq_n,
    output logic             ic_rst_req,
    output logic [3:0]       port_rst_req
);
    ev_bank_t pulse_bank;
    ev_bank_t ev_q;
    byte_t    int_sum;
    byte_t    mask_q;
    logic     gen_en;
    cmd_t     cmd_now;

    assign pulse_bank[0]       = {ev_pg_chg,   ev_pe_chg};
    assign pulse_bank[1]       = {ev_cls_done, ev_det_done};
    assign pulse_bank[2]       = {ev_disc,     ev_ocut};
    assign pulse_bank[3]       = {ev_ilim,     ev_start};
    assign pulse_bank[SUP_IDX] = {ev_supply,   {(BYTE_W-PORTS){1'b0}}};

    pse_evt_cmd u_cmd (
        .clk          (clk),
        .rst          (rst),
        .hit          (wr_en && cmd_addr == A_CMD),
        .wr_data      (wr_data),
        .now          (cmd_now),
        .ic_rst_req   (ic_rst_req),
        .port_rst_req (port_rst_req)
    );

    for (genvar i = 0; i < EV_REGS; i++) begin : g_ev
        logic clr;
        assign clr = cmd_now.clr_all ||
                     (rd_en && cmd_addr == (ev_addr(i) | 8'h01));
        if (i == SUP_IDX) begin : g_sup
            pse_evt_reg #(.RST_VAL(SUP_RST), .VALID(SUP_VALID)) u_reg (
                .clk (clk), .rst (rst), .clr (clr),
                .set (pulse_bank[i]), .q (ev_q[i])
            );
        end else begin : g_port
            pse_evt_reg #(.RST_VAL(8'h00), .VALID(8'hFF)) u_reg (
                .clk (clk), .rst (rst), .clr (clr),
                .set (pulse_bank[i]), .q (ev_q[i])
            );
        end
    end

    assign int_sum = summarize(ev_q);

    pse_evt_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .wr_mask     (wr_en && cmd_addr == A_MASK),
        .wr_gen      (wr_en && cmd_addr == A_GEN),
        .wr_data     (wr_data),
        .sum         (int_sum),
        .new_sum     (summarize(pulse_bank)),
        .release_req (cmd_now.release_irq),
        .mask_q      (mask_q),
        .gen_en      (gen_en),
        .irq_n       (irq_n)
    );

    always_comb begin
        rd_data = '0;
        unique case (cmd_addr)
            A_SUM:   rd_data = int_sum;
            A_MASK:  rd_data = mask_q;
            A_GEN:   rd_data = {gen_en, {(BYTE_W-1){1'b0}}};
            default: begin
                for (int i = 0; i < EV_REGS; i++) begin
                    if (cmd_addr[7:1] == ev_addr(i)[7:1]) rd_data = ev_q[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/pse_evt_bank_chk.sv
`timescale 1ns/1ps
module pse_evt_bank_chk
    import pse_evt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] cmd_addr,
    input logic [7:0] wr_data,
    input logic       wr_en,
    input logic       rd_en,
    input ev_bank_t   pulse,
    input ev_bank_t   evt,
    input byte_t      sum,
    input byte_t      mask,
    input logic       gen_en,
    input logic       irq_n,
    input logic       ic_rst_req,
    input logic [3:0] port_rst_req
);
    // R2 and R10: every pulse is visible in the bank on the following cycle
    a_r2_no_lost_pulse: assert property (@(posedge clk) disable iff (rst)
        (pulse != '0) |=> ((evt & $past(pulse)) == $past(pulse)));

    // R3: a clearing read of 03h with no coincident pulse empties the register
    a_r3_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cmd_addr == 8'h03 && pulse[0] == '0) |=> (evt[0] == '0));

    // R4: reserved supply bits never set
    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (evt[SUP_IDX][3:0] == 4'h0));

    // R7: low line implies an enabled, unmasked flag
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
        (!irq_n) |-> (gen_en && (sum & mask) != '0));

    // R7: disabled means the line is high
    a_r7_irq_disabled: assert property (@(posedge clk) disable iff (rst)
        (!gen_en) |-> irq_n);

    // R9: clear-all with no coincident pulse empties every register
    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_addr == 8'h1A && wr_data[7] && pulse == '0) |=> (evt == '0));

    // R11: reset requests only follow a command write
    a_r11_req_source: assert property (@(posedge clk) disable iff (rst)
        (ic_rst_req || port_rst_req != '0) |-> $past(wr_en && cmd_addr == 8'h1A));
endmodule

bind pse_evt_bank pse_evt_bank_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_addr     (cmd_addr),
    .wr_data      (wr_data),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .pulse        (pulse_bank),
    .evt          (ev_q),
    .sum          (int_sum),
    .mask         (mask_q),
    .gen_en       (gen_en),
    .irq_n        (irq_n),
    .ic_rst_req   (ic_rst_req),
    .port_rst_req (port_rst_req)
);

// File: tb/test_pse_evt_bank.sv
`timescale 1ns/1ps
module test_pse_evt_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cmd_addr = '0, wr_data = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] ev_pg_chg = '0, ev_pe_chg = '0, ev_cls_done = '0, ev_det_done = '0;
    logic [3:0] ev_disc = '0, ev_ocut = '0, ev_ilim = '0, ev_start = '0, ev_supply = '0;
    logic       irq_n, ic_rst_req;
    logic [3:0] port_rst_req;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pse_evt_bank i_pse_evt_bank (.*);

    typedef struct packed { logic [2:0] idx; logic [7:0] pat; } vec_t;
    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{3'd0, 8'h81}, '{3'd1, 8'h42}, '{3'd2, 8'h10}, '{3'd2, 8'h21},
        '{3'd3, 8'h08}, '{3'd3, 8'h80}, '{3'd4, 8'hFF}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr_pulses();
        {ev_pg_chg, ev_pe_chg, ev_cls_done, ev_det_done} = '0;
        {ev_disc, ev_ocut, ev_ilim, ev_start, ev_supply} = '0;
    endtask

    task automatic set_pulse(input logic [2:0] idx, input logic [7:0] p);
        case (idx)
            3'd0: {ev_pg_chg, ev_pe_chg}     = p;
            3'd1: {ev_cls_done, ev_det_done} = p;
            3'd2: {ev_disc, ev_ocut}         = p;
            3'd3: {ev_ilim, ev_start}        = p;
            default: ev_supply               = p[7:4];
        endcase
    endtask

    // expected summary per R5
    function automatic logic [7:0] exp_sum(input logic [2:0] idx, input logic [7:0] p);
        logic [7:0] s = '0;
        case (idx)
            3'd0: begin s[1] = |p[7:4]; s[0] = |p[3:0]; end
            3'd1: begin s[4] = |p[7:4]; s[3] = |p[3:0]; end
            3'd2: begin s[2] = |p[7:4]; s[5] = |p[3:0]; end
            3'd3: s[6] = |p;
            default: s[7] = |p[7:4];
        endcase
        return s;
    endfunction

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        clr_pulses();
        cmd_addr = a; rd_en = 1'b0; wr_en = 1'b0;
        #1 d = rd_data;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        clr_pulses();
        cmd_addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #1 d = rd_data;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        clr_pulses();
        cmd_addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] idx, input logic [7:0] p);
        @(negedge clk);
        clr_pulses();
        set_pulse(idx, p);
        cmd_addr = 8'h00; rd_en = 1'b0; wr_en = 1'b0;
        @(posedge clk); #1 clr_pulses();
    endtask

    task automatic irq_is(input string tag, input logic exp);
        @(negedge clk); #1;
        check(tag, {7'b0, irq_n}, {7'b0, exp});
    endtask

    initial begin
        #(5.0 * 100000);
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        peek(8'h00, d); check("R1 sum", d, 8'h80);
        peek(8'h01, d); check("R1 mask", d, 8'h80);
        peek(8'h17, d); check("R1 gen", d, 8'h80);
        peek(8'h0A, d); check("R1 supply", d, 8'h70);
        peek(8'h02, d); check("R1 ev02", d, 8'h00);
        peek(8'h08, d); check("R1 ev08", d, 8'h00);
        irq_is("R1 irq_n", 1'b0);

        // R4 supply clearing alias
        rd(8'h0B, d); check("R4 clr read", d, 8'h70);
        peek(8'h0A, d); check("R4 after clear", d, 8'h00);
        irq_is("R7 idle irq_n", 1'b1);

        // R2/R3/R5 table walk
        for (int k = 0; k < NV; k++) begin
            logic [7:0] ex;
            logic [7:0] a;
            ex = (VT[k].idx == 3'd4) ? (VT[k].pat & 8'hF0) : VT[k].pat;
            a  = 8'h02 + {4'b0, VT[k].idx, 1'b0};
            pulse(VT[k].idx, VT[k].pat);
            peek(a, d);        check("R2 latch", d, ex);
            peek(a, d);        check("R3 even no side effect", d, ex);
            peek(8'h00, d);    check("R5 summary", d, exp_sum(VT[k].idx, VT[k].pat));
            rd(a | 8'h01, d);  check("R3 odd read", d, ex);
            peek(a, d);        check("R3 cleared", d, 8'h00);
        end
        peek(8'h0A, d); check("R4 rsvd bits", d, 8'h00);

        // R12 ignored writes, unmapped reads
        wr(8'h02, 8'hFF); peek(8'h02, d); check("R12 ro write", d, 8'h00);
        wr(8'h30, 8'hFF); peek(8'h30, d); check("R12 unmapped", d, 8'h00);
        peek(8'h1A, d); check("R11 cmd reads 0", d, 8'h00);

        // R10 pulse meets a clearing read
        pulse(3'd0, 8'h01);
        @(negedge clk);
        clr_pulses(); ev_pg_chg = 4'b0010; cmd_addr = 8'h03; rd_en = 1'b1;
        #1 check("R10 read old", rd_data, 8'h01);
        @(posedge clk); #1 begin rd_en = 1'b0; clr_pulses(); end
        peek(8'h02, d); check("R10 kept", d, 8'h20);

        // R9 clear-all with a coincident pulse (R10)
        pulse(3'd1, 8'h11);
        pulse(3'd3, 8'h02);
        @(negedge clk);
        clr_pulses(); ev_ocut = 4'b0100; cmd_addr = 8'h1A; wr_data = 8'h80; wr_en = 1'b1;
        @(posedge clk); #1 begin wr_en = 1'b0; clr_pulses(); end
        peek(8'h02, d); check("R9 ev02", d, 8'h00);
        peek(8'h04, d); check("R9 ev04", d, 8'h00);
        peek(8'h08, d); check("R9 ev08", d, 8'h00);
        peek(8'h06, d); check("R10 clear-all kept", d, 8'h04);
        rd(8'h07, d);

        // R6/R7 mask and enable
        pulse(3'd2, 8'h40);
        irq_is("R7 masked", 1'b1);
        wr(8'h01, 8'h04); peek(8'h01, d); check("R6 mask rw", d, 8'h04);
        irq_is("R7 unmasked", 1'b0);
        wr(8'h17, 8'h00); peek(8'h17, d); check("R6 gen off", d, 8'h00);
        irq_is("R7 disabled", 1'b1);
        wr(8'h17, 8'hFF); peek(8'h17, d); check("R6 gen only bit7", d, 8'h80);
        irq_is("R7 enabled", 1'b0);

        // R8 release and re-arm
        wr(8'h1A, 8'h40);
        irq_is("R8 released", 1'b1);
        peek(8'h00, d); check("R8 flag kept", d, 8'h04);
        pulse(3'd0, 8'h01);
        irq_is("R8 masked-out no rearm", 1'b1);
        pulse(3'd2, 8'h10);
        irq_is("R8 rearm", 1'b0);

        // R11 push-button pulses
        wr(8'h1A, 8'h1F);
        check("R11 ic req", {7'b0, ic_rst_req}, 8'h01);
        check("R11 port req", {4'b0, port_rst_req}, 8'h0F);
        @(posedge clk); #1;
        check("R11 ic self clear", {7'b0, ic_rst_req}, 8'h00);
        check("R11 port self clear", {4'b0, port_rst_req}, 8'h00);
        peek(8'h06, d); check("R11 events untouched", d, 8'h50);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule